// File: doc/BRIEF.md
# DMA Task Interrupt Pending Unit

This block gathers the completion events of sixteen DMA tasks into one interrupt request for the peripheral interrupt group. Each task has its own pending bit and its own mask bit, both at bit position n for task n. A single-cycle event pulse from a task sets its pending bit. Software clears pending bits by writing ones to the pending register. A mask bit set to 1 keeps that task out of the combined request.

The combined request is raised whenever some task is both pending and unmasked. Alongside it the block gives the index of the lowest-numbered task in that set, with a valid flag. The interrupt handler can therefore go straight to the right task without scanning. The register port is plain control: a write strobe with a select, and a combinational read with a select. It has no handshake and never stalls.

Top module: `tsk_irq_pend`

## Requirements
- R1: While reset is held, and at the first cycle after it, every pending bit is 0, every mask bit is 1, and `irq` and `svc_valid` are 0.
- R2: A 1 on `task_evt[n]` in a cycle sets pending bit n from the next cycle on. This happens whatever the mask bit n holds.
- R3: A write with `wr_sel`=0 clears each pending bit whose `wr_data` bit is 1. Pending bits whose `wr_data` bit is 0 keep their value.
- R4: When an event and a clearing write hit the same pending bit in one cycle, that bit is 1 afterwards.
- R5: A write with `wr_sel`=1 loads `wr_data` into the mask register in the next cycle. A mask bit of 1 disables its task.
- R6: `irq` is 1 exactly when at least one task is pending with its mask bit at 0.
- R7: `svc_valid` equals `irq`. While it is 1, `svc_idx` is the lowest n that is pending and unmasked. While it is 0, `svc_idx` is 0.
- R8: `rd_data` shows the pending register when `rd_sel`=0 and the mask register when `rd_sel`=1, in the same cycle.
- R9: A mask write does not change any pending bit.
- R10: Writing all ones to the pending register and then to the mask register returns the block to its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| task_evt | input | 16 | One event pulse line per task |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = pending (write one to clear), 1 = mask |
| wr_data | input | 16 | Write data, bit n belongs to task n |
| rd_sel | input | 1 | Read target: 0 = pending, 1 = mask |
| rd_data | output | 16 | Selected register contents |
| irq | output | 1 | Combined request toward the peripheral group |
| svc_idx | output | 4 | Lowest pending and unmasked task |
| svc_valid | output | 1 | `svc_idx` is meaningful |

## Verification
Directed sequences cover the cases that separate the rules:
- Events arrive while everything is masked, which shows that pending is independent of the mask.
- Two tasks are pending at once, and the lower one is cleared, which shows that the encoder tracks the lowest survivor.
- A clear write carries zero bits, which shows that zeros leave bits alone.
- An event collides with a clear on the same bit, which shows the ordering between the two.

Random streams then mix sparse multi-bit events with random clear and mask writes. Each cycle's outputs are compared against a bench model, and this catches wrong bit selection, inverted mask sense and wrong encoder direction.

// File: rtl/tsk_pkg.sv
package tsk_pkg;
  localparam int NTASK_DEF = 16;

  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tsk_pend_bits.sv
module tsk_pend_bits #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] pend
);
  // one flop per task; a set in the same cycle as a clear wins
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        bit_q <= 1'b0;
      else if (evt[g])
        bit_q <= 1'b1;
      else if (clr_en && clr_bits[g])
        bit_q <= 1'b0;
    end
    assign pend[g] = bit_q;
  end
endmodule

// File: rtl/tsk_mask_reg.sv
module tsk_mask_reg #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      mask <= '1;
    else if (we)
      mask <= wdata;
  end
endmodule

// File: rtl/tsk_lsb_enc.sv
module tsk_lsb_enc #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = i[W-1:0];
    end
  end
  assign any = |vec;
endmodule

// File: rtl/tsk_irq_pend.sv
module tsk_irq_pend
  import tsk_pkg::*;
#(
  parameter int NTASK = NTASK_DEF,
  localparam int IDXW = (NTASK > 1) ? $clog2(NTASK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTASK-1:0] task_evt,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [NTASK-1:0] wr_data,
  input  logic             rd_sel,
  output logic [NTASK-1:0] rd_data,
  output logic             irq,
  output logic [IDXW-1:0]  svc_idx,
  output logic             svc_valid
);
  logic [NTASK-1:0] pend_q;
  logic [NTASK-1:0] mask_q;
  logic [NTASK-1:0] live;
  logic             pend_wr;
  logic             mask_wr;
  logic             any_live;

  assign pend_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_PEND);
  assign mask_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);

  tsk_pend_bits #(.N(NTASK)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (task_evt),
    .clr_en   (pend_wr),
    .clr_bits (wr_data),
    .pend     (pend_q)
  );

  tsk_mask_reg #(.N(NTASK)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mask_wr),
    .wdata (wr_data),
    .mask  (mask_q)
  );

  assign live = pend_q & ~mask_q;

  tsk_lsb_enc #(.N(NTASK), .W(IDXW)) u_enc (
    .vec (live),
    .idx (svc_idx),
    .any (any_live)
  );

  assign irq       = any_live;
  assign svc_valid = any_live;
  assign rd_data   = (reg_sel_e'(rd_sel) == SEL_MASK) ? mask_q : pend_q;
endmodule

// File: rtl/tsk_irq_pend_chk.sv
module tsk_irq_pend_chk #(
  parameter int NTASK = 16,
  localparam int IDXW = (NTASK > 1) ? $clog2(NTASK) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NTASK-1:0] evt,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [NTASK-1:0] wr_data,
  input logic [NTASK-1:0] pend,
  input logic [NTASK-1:0] mask,
  input logic             irq,
  input logic [IDXW-1:0]  idx,
  input logic             valid
);
  logic [NTASK-1:0] below;
  assign below = ~({NTASK{1'b1}} << idx);

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (pend == '0 && mask == '1 && !irq && !valid));

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend & $past(evt)) == $past(evt)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> ((pend & $past(wr_data & ~evt)) == '0));

  p_only_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(evt)) == '0));

  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (mask == $past(wr_data)));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> ((pend & ~mask) == '0));

  p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid == irq);

  p_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (pend[idx] && !mask[idx] && ((pend & ~mask & below) == '0)));

  p_idx_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (idx == '0));

  p_mask_keeps_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && evt == '0) |=> (pend == $past(pend)));
endmodule

bind tsk_irq_pend tsk_irq_pend_chk #(.NTASK(NTASK)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt     (task_evt),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .pend    (pend_q),
  .mask    (mask_q),
  .irq     (irq),
  .idx     (svc_idx),
  .valid   (svc_valid)
);

// File: tb/tb_tsk_irq_pend.sv
module tb_tsk_irq_pend;
  localparam int N = 16;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] task_evt = '0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic         rd_sel = 1'b0;
  logic [N-1:0] rd_data;
  logic         irq;
  logic [W-1:0] svc_idx;
  logic         svc_valid;

  int total = 0;
  int bad = 0;
  logic [N-1:0] m_pend = '0;
  logic [N-1:0] m_mask = '1;

  always #2.5 clk = ~clk;

  tsk_irq_pend dut (
    .clk(clk), .rst_n(rst_n), .task_evt(task_evt), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq), .svc_idx(svc_idx), .svc_valid(svc_valid)
  );

  function automatic logic [W-1:0] low_idx(logic [N-1:0] v);
    logic [W-1:0] r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = i[W-1:0];
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock with given inputs; model follows the requirements
  task automatic step(logic [N-1:0] e, logic we, logic sel, logic [N-1:0] wd);
    task_evt = e; wr_en = we; wr_sel = sel; wr_data = wd;
    @(posedge clk);
    if (we && !sel) m_pend = m_pend & ~wd;
    m_pend = m_pend | e;
    if (we && sel) m_mask = wd;
    @(negedge clk);
    task_evt = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic check_all(string req);
    logic [N-1:0] live;
    live = m_pend & ~m_mask;
    rd_sel = 1'b0; #0.5;
    chk("R8", "rd pend", 32'(rd_data), 32'(m_pend));
    rd_sel = 1'b1; #0.5;
    chk("R8", "rd mask", 32'(rd_data), 32'(m_mask));
    rd_sel = 1'b0;
    chk(req, "irq R6", 32'(irq), 32'(|live));
    chk(req, "valid R7", 32'(svc_valid), 32'(|live));
    chk(req, "idx R7", 32'(svc_idx), 32'(low_idx(live)));
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk("R1", "irq in reset", 32'(irq), 32'd0);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2, R9: events latch while masked, no irq
    step(16'h0220, 1'b0, 1'b0, '0);
    chk("R2", "pend set while masked", 32'(m_pend), 32'h0220);
    check_all("R2");
    step('0, 1'b1, 1'b1, 16'h0000);
    check_all("R9");
    chk("R7", "lowest of 5,9", 32'(svc_idx), 32'd5);

    // R3: clear bit 5, then a zero write leaves bit 9
    step('0, 1'b1, 1'b0, 16'h0020);
    check_all("R3");
    chk("R3", "idx after clear", 32'(svc_idx), 32'd9);
    step('0, 1'b1, 1'b0, 16'h0000);
    check_all("R3");

    // R4: event and clear on bit 3 together
    step(16'h0008, 1'b1, 1'b0, 16'h0008);
    check_all("R4");
    chk("R4", "bit3 kept", 32'(svc_idx), 32'd3);

    // R5, R6: mask bit 3 and 9 -> no irq
    step('0, 1'b1, 1'b1, 16'h0208);
    check_all("R5");
    chk("R6", "all masked irq", 32'(irq), 32'd0);

    // R7: highest task alone
    step(16'h8000, 1'b0, 1'b0, '0);
    check_all("R7");
    chk("R7", "idx 15", 32'(svc_idx), 32'd15);

    // R10: init sequence
    step('0, 1'b1, 1'b0, 16'hffff);
    step('0, 1'b1, 1'b1, 16'hffff);
    check_all("R10");
    chk("R10", "pend zero", 32'(m_pend), 32'd0);

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [N-1:0] e;
      logic we, sel;
      logic [N-1:0] wd;
      e   = N'($urandom & $urandom & $urandom);
      we  = ($urandom % 3) == 0;
      sel = $urandom % 2;
      wd  = N'($urandom);
      step(e, we, sel, wd);
      check_all("R6");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule